// File: doc/BRIEF.md
# Read-Only Key-Status Serial Slave

This block is a two-wire serial bus slave that answers read requests only. It samples the bus clock and data lines with a fast system clock and recognises START and STOP conditions. When the address byte carries the fixed device address with the read bit set, it acknowledges and sends the on/off state of a bank of touch keys, one bit per key. The key count mode sets how many status bytes it offers: one byte in narrow mode, or every byte of the key vector in wide mode. The master acknowledges each byte to ask for the next and does not acknowledge the last one.

The key vector is a set of level signals, not a stream, so it carries no valid/ready handshake. The block copies it into a snapshot when the address matches, and every byte of that read comes from the same instant. The bus side has no back-pressure of its own because the block never stretches the clock. Each SCL high and low phase must last at least `SYNC_STAGES + 3` system clocks, which supports a 400 kHz bus with a system clock of a few MHz or faster.

Top module: `kstat_i2c_rd`

## Requirements
- R1: After reset the SDA pull-low enable is off and the busy flag is low.
- R2: A START (SDA falling while SCL is high) raises busy and begins address reception, and a STOP (SDA rising while SCL is high) drops busy and releases SDA.
- R3: An address byte equal to 1010111 followed by R/W = 1 is acknowledged: SDA is pulled low for the whole high phase of the ninth clock.
- R4: An address byte with R/W = 0, or with any other 7-bit address, gets no acknowledge, and SDA stays released until the next STOP or START.
- R5: Each data byte is sent MSB first. Bit 7 holds the lowest-numbered key of that byte and bit 0 the highest. A touched key (1) is sent as a released, high SDA and an untouched key as a pulled-low SDA.
- R6: With wide_i = 1 and KEY_W = 16, byte 0 carries keys 0 to 7 and, after a master ACK, byte 1 carries keys 8 to 15.
- R7: With wide_i = 0, only byte 0 (keys 0 to 7) is sent. If the master acknowledges it, SDA stays released afterwards, so the master reads all ones.
- R8: When the master does not acknowledge a byte (SDA high in the ninth clock), the slave keeps SDA released until STOP.
- R9: The key vector and the mode are captured when the address matches. Changes to keys_i after that do not alter the bytes of the same read.
- R10: The slave changes its SDA pull enable only while SCL is low.
- R11: A START seen in the middle of a transfer abandons it and restarts address reception. A following valid read returns a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| keys_i | input | KEY_W | Key state, 1 = touched, bit n = key n |
| wide_i | input | 1 | 1 = send all KEY_W/8 bytes, 0 = send one byte |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release SDA |
| busy_o | output | 1 | High from START until STOP |

## Verification
The bench builds the block with its default parameters: 16 keys, a two-stage synchronizer and the address 1010111. It runs the bus with six system clocks per SCL quarter phase, close to the slowest ratio the synchronizer accepts. Every 7-bit address is tried with the read bit set, so exactly one of the 128 is acknowledged. Walking-one and walking-zero patterns in wide mode and 48 varied narrow-mode patterns cover every bit position of both bytes and both mode lengths. Directed reads cover the write bit, a master NACK, a key change during a read and a START that cuts into a data byte.

// File: rtl/kstat_i2c_pkg.sv
package kstat_i2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_TX,
    S_MACK,
    S_HOLD
  } rd_state_e;

  localparam logic [6:0] DEFAULT_DEV_ADDR = 7'b1010111;
endpackage

// File: rtl/kstat_sync.sv
module kstat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // bus lines idle high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], in_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/kstat_cond.sv
module kstat_cond (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // data edges while the clock is high are bus conditions, not data
  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i;
endmodule

// File: rtl/kstat_tx.sv
module kstat_tx #(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             next_i,
  input  logic             shift_i,
  input  logic [KEY_W-1:0] keys_i,
  input  logic             wide_i,
  output logic             msb_o,
  output logic             second_o,
  output logic             next_msb_o,
  output logic             more_o
);
  localparam int BYTES = KEY_W / 8;
  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) + 1 : 1;

  logic [KEY_W-1:0] snap;
  logic [IDXW-1:0]  idx;
  logic [IDXW-1:0]  last;
  logic [7:0]       sh;
  logic [7:0]       upcoming;

  // byte k: key 8k in bit 7 down to key 8k+7 in bit 0
  function automatic logic [7:0] pick(input logic [KEY_W-1:0] v, input int k);
    logic [7:0] r;
    r = 8'hFF;
    if (k < BYTES) begin
      for (int j = 0; j < 8; j++) r[7-j] = v[k*8+j];
    end
    return r;
  endfunction

  always_comb upcoming = pick(snap, int'(idx) + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      idx  <= '0;
      last <= '0;
      sh   <= 8'hFF;
    end else if (load_i) begin
      snap <= keys_i;
      idx  <= '0;
      last <= wide_i ? IDXW'(BYTES - 1) : '0;
      sh   <= pick(keys_i, 0);
    end else if (next_i) begin
      idx  <= idx + 1'b1;
      sh   <= upcoming;
    end else if (shift_i) begin
      sh   <= {sh[6:0], 1'b1};
    end
  end

  assign msb_o      = sh[7];
  assign second_o   = sh[6];
  assign next_msb_o = upcoming[7];
  assign more_o     = (idx != last);
endmodule

// File: rtl/kstat_fsm.sv
module kstat_fsm
  import kstat_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEFAULT_DEV_ADDR
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_rise_i,
  input  logic      scl_fall_i,
  input  logic      sda_lvl_i,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      tx_msb_i,
  input  logic      tx_second_i,
  input  logic      tx_next_msb_i,
  input  logic      tx_more_i,
  output logic      load_o,
  output logic      next_o,
  output logic      shift_o,
  output logic      pull_o,
  output logic      busy_o,
  output rd_state_e state_o
);
  localparam logic [7:0] READ_BYTE = {DEV_ADDR, 1'b1};

  rd_state_e  state, nstate;
  logic [3:0] cnt, ncnt;
  logic [7:0] addr_sr, naddr;
  logic       macked, nmacked;
  logic       pull, npull;

  always_comb begin
    nstate  = state;
    ncnt    = cnt;
    naddr   = addr_sr;
    nmacked = macked;
    npull   = pull;
    load_o  = 1'b0;
    next_o  = 1'b0;
    shift_o = 1'b0;
    if (stop_i) begin
      nstate = S_IDLE;
      npull  = 1'b0;
    end else if (start_i) begin
      nstate = S_ADDR;
      ncnt   = '0;
      npull  = 1'b0;
    end else begin
      unique case (state)
        S_ADDR: begin
          if (scl_rise_i) begin
            naddr = {addr_sr[6:0], sda_lvl_i};
            ncnt  = cnt + 4'd1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            if (addr_sr == READ_BYTE) begin
              nstate = S_AACK;
              npull  = 1'b1;
              load_o = 1'b1;
            end else begin
              nstate = S_HOLD;
            end
          end
        end
        S_AACK: begin
          if (scl_fall_i) begin
            nstate = S_TX;
            ncnt   = '0;
            npull  = ~tx_msb_i;
          end
        end
        S_TX: begin
          if (scl_fall_i) begin
            if (cnt == 4'd7) begin
              nstate = S_MACK;
              npull  = 1'b0;
            end else begin
              shift_o = 1'b1;
              npull   = ~tx_second_i;
              ncnt    = cnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise_i) begin
            nmacked = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (macked && tx_more_i) begin
              nstate = S_TX;
              next_o = 1'b1;
              ncnt   = '0;
              npull  = ~tx_next_msb_i;
            end else begin
              nstate = S_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_sr <= '0;
      macked  <= 1'b0;
      pull    <= 1'b0;
    end else begin
      state   <= nstate;
      cnt     <= ncnt;
      addr_sr <= naddr;
      macked  <= nmacked;
      pull    <= npull;
    end
  end

  assign pull_o  = pull;
  assign busy_o  = (state != S_IDLE);
  assign state_o = state;
endmodule

// File: rtl/kstat_i2c_rd.sv
module kstat_i2c_rd
  import kstat_i2c_pkg::*;
#(
  parameter int         KEY_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = DEFAULT_DEV_ADDR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [KEY_W-1:0] keys_i,
  input  logic             wide_i,
  output logic             sda_pull_o,
  output logic             busy_o
);
  logic      scl_lvl, scl_rise, scl_fall;
  logic      sda_lvl, sda_rise, sda_fall;
  logic      start_det, stop_det;
  logic      tx_msb, tx_second, tx_next_msb, tx_more;
  logic      ld, nxt, shf;
  rd_state_e state;

  kstat_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .in_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  kstat_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .in_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  kstat_cond u_cond (
    .scl_lvl_i(scl_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  kstat_tx #(.KEY_W(KEY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .next_i(nxt), .shift_i(shf),
    .keys_i(keys_i), .wide_i(wide_i),
    .msb_o(tx_msb), .second_o(tx_second), .next_msb_o(tx_next_msb),
    .more_o(tx_more)
  );

  kstat_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_lvl_i(sda_lvl),
    .start_i(start_det), .stop_i(stop_det),
    .tx_msb_i(tx_msb), .tx_second_i(tx_second),
    .tx_next_msb_i(tx_next_msb), .tx_more_i(tx_more),
    .load_o(ld), .next_o(nxt), .shift_o(shf),
    .pull_o(sda_pull_o), .busy_o(busy_o), .state_o(state)
  );
endmodule

// File: rtl/kstat_i2c_rd_chk.sv
module kstat_i2c_rd_chk
  import kstat_i2c_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_lvl,
  input logic      start_det,
  input logic      stop_det,
  input logic      busy,
  input logic      pull,
  input rd_state_e state
);
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pull);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> busy);

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy && !pull);

  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pull != $past(pull)) |-> !scl_lvl);

  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> !pull);

  p_restart_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> state == S_ADDR);
endmodule

bind kstat_i2c_rd kstat_i2c_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
  .start_det(start_det), .stop_det(stop_det),
  .busy(busy_o), .pull(sda_pull_o), .state(state)
);

// File: tb/kstat_i2c_rd_bench.sv
module kstat_i2c_rd_bench;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [15:0] keys = 16'h0000;
  logic        wide = 1'b1;
  logic        sda_pull_o, busy_o;
  wire         sda_line = sda_m & ~sda_pull_o;

  int checks = 0;
  int errors = 0;
  int hi_changes = 0;
  logic prev_pull = 1'b0;

  always #2 clk = ~clk;

  kstat_i2c_rd u_kstat_i2c_rd (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .keys_i(keys), .wide_i(wide), .sda_pull_o(sda_pull_o), .busy_o(busy_o)
  );

  always @(negedge clk) begin
    if (rst_n && scl_m && sda_pull_o != prev_pull) hi_changes++;
    prev_pull <= sda_pull_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_addr(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
  endtask

  function automatic logic [7:0] expect_byte(input logic [15:0] k, input int n);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[7-j] = k[n*8+j];
    return r;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic       a;
    logic [7:0] b0, b1;
    logic [15:0] k0;
    repeat (5) @(negedge clk);
    chk("R1 pull after reset", int'(sda_pull_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    rst_n = 1'b1;
    q();

    // R3 R4: every 7-bit address with the read bit
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      if (ad == 0) chk("R2 busy after start", int'(busy_o), 1);
      send_addr({ad[6:0], 1'b1}, a);
      chk(ad == 7'h57 ? "R3 ack on own address" : "R4 nack other address",
          int'(a), ad == 7'h57 ? 0 : 1);
      bus_stop();
    end
    chk("R2 busy after stop", int'(busy_o), 0);

    // R4: write bit gets no ack, line stays released
    keys = 16'h0000;
    bus_start();
    send_addr(8'hAE, a);
    chk("R4 nack on write", int'(a), 1);
    read_byte(b0);
    chk("R4 released after write", int'(b0), 8'hFF);
    bus_stop();

    // R5 R6: wide mode, walking ones, walking zeros, mixed
    wide = 1'b1;
    for (int n = 0; n < 40; n++) begin
      if (n < 16)      keys = 16'h1 << n;
      else if (n < 32) keys = ~(16'h1 << (n - 16));
      else             keys = 16'(n * 40503);
      bus_start();
      send_addr(8'hAF, a);
      chk("R3 ack wide", int'(a), 0);
      read_byte(b0);
      bit_out(1'b0);
      read_byte(b1);
      bit_out(1'b1);
      bus_stop();
      chk("R5 R6 byte0 keys 0-7", int'(b0), int'(expect_byte(keys, 0)));
      chk("R6 byte1 keys 8-15", int'(b1), int'(expect_byte(keys, 1)));
    end

    // R7: narrow mode, one byte then released
    wide = 1'b0;
    for (int n = 0; n < 48; n++) begin
      keys = 16'((n * 5 + 3) * 16'h0101 ^ (n << 9));
      bus_start();
      send_addr(8'hAF, a);
      read_byte(b0);
      bit_out(1'b0);
      read_byte(b1);
      bit_out(1'b1);
      bus_stop();
      chk("R7 narrow byte0", int'(b0), int'(expect_byte(keys, 0)));
      chk("R7 nothing after one byte", int'(b1), 8'hFF);
    end

    // R8: master NACK in wide mode stops transmission
    wide = 1'b1;
    keys = 16'h0000;
    bus_start();
    send_addr(8'hAF, a);
    read_byte(b0);
    bit_out(1'b1);
    read_byte(b1);
    chk("R8 byte0 before nack", int'(b0), 8'h00);
    chk("R8 released after nack", int'(b1), 8'hFF);
    chk("R8 busy until stop", int'(busy_o), 1);
    bus_stop();
    chk("R8 idle after stop", int'(busy_o), 0);

    // R9: snapshot at address match
    k0 = 16'h3C81;
    keys = k0;
    bus_start();
    send_addr(8'hAF, a);
    keys = 16'hC37E;
    wide = 1'b0;
    read_byte(b0);
    bit_out(1'b0);
    read_byte(b1);
    bit_out(1'b1);
    bus_stop();
    chk("R9 snapshot byte0", int'(b0), int'(expect_byte(k0, 0)));
    chk("R9 snapshot byte1 and mode", int'(b1), int'(expect_byte(k0, 1)));

    // R11: START inside a data byte restarts address reception
    wide = 1'b1;
    keys = 16'h0010;
    bus_start();
    send_addr(8'hAF, a);
    for (int i = 0; i < 4; i++) bit_in(b0[i]);
    keys = 16'h5A3C;
    bus_start();
    chk("R11 busy after restart", int'(busy_o), 1);
    send_addr(8'hAF, a);
    chk("R11 ack after restart", int'(a), 0);
    read_byte(b0);
    bit_out(1'b0);
    read_byte(b1);
    bit_out(1'b1);
    bus_stop();
    chk("R11 fresh byte0", int'(b0), int'(expect_byte(16'h5A3C, 0)));
    chk("R11 fresh byte1", int'(b1), int'(expect_byte(16'h5A3C, 1)));

    chk("R10 pull changes while SCL high", hi_changes, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule